// File: doc/BRIEF.md
# Sliding-Window Histogram Median Filter

This block computes a running median over the most recent accepted samples of an unsigned stream. Instead of keeping the window sorted, it holds one counter for every value a sample can take. Together the counters form a cumulative histogram: a counter at index `b` holds the number of window samples whose value is `b` or lower. Each new sample is turned into a thermometer mask, so every bin at or above its value moves. A shift-register delay line returns the sample that leaves the window. That sample's mask is applied in the opposite direction in the same cycle, so a bin that both samples touch keeps its count.

The median rank comes from the top bin, which always equals the number of samples in the window. Each bin compares its count against that rank. A lowest-index priority encoder then picks the first bin that reaches the rank, and the index of that bin is the median. The area grows with the number of possible sample values and not with the window length. One result leaves the block per accepted sample, and results can follow each other on consecutive cycles. It suits long one-dimensional windows, such as samples taken along a line through an image.

Top module: `hist_median`

## Requirements
- R1: Synchronous active-high `rst` clears `out_valid`, every bin count and every delay-line entry together with its valid flag. The first sample accepted after reset therefore comes out alone as its own median.
- R2: `out_valid` is high in the cycle that follows the second rising edge after a cycle with `in_valid` high, and is low in every other cycle.
- R3: While fewer than `WINDOW` samples have been accepted since reset, let `c` be the number accepted so far. The result is the element at zero-based position `floor(c/2)` of those `c` samples sorted in ascending order.
- R4: Once the window is full, the result is the median of the last `WINDOW` accepted samples. This is the element at one-based position `(WINDOW+1)/2` in ascending order.
- R5: When a sample arrives at a full window, the sample accepted `WINDOW` samples earlier leaves in the same cycle. Older samples have no effect on any later result.
- R6: A cycle with `in_valid` low changes neither the window contents nor the histogram. Idle gaps of any length between samples leave the results unchanged.
- R7: Repeated sample values are each counted separately.
- R8: The smallest value (0) and the largest value (2^SAMPLE_W-1) are handled like any other value and can be returned as the median.
- R9: Samples accepted on consecutive cycles produce one result per cycle, in the same order, with no cycle lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept `in_data` this cycle |
| in_data | input | SAMPLE_W | Unsigned sample value |
| out_valid | output | 1 | `out_data` holds a median this cycle |
| out_data | output | SAMPLE_W | Median of the current window |

## Verification
Each value is first sent alone after a reset, which shows that the thermometer mask starts at the right bin for every code, including both extremes. Ascending and descending ramps fill the window and then slide it. A fault in the removal path or in the rank taken while the window is partial shows up as a result shifted by one. A stream of values in a narrow range with random idle gaps creates many duplicates and stalls, which separates correct hold behaviour from counting the idle cycles. A reset in the middle of a stream of large values, followed by a single small sample, shows whether any stale count or delay-line entry survived.

// File: rtl/hist_median_pkg.sv
package hist_median_pkg;
   // Counter width able to hold 0..window
   function automatic int count_width(input int window);
      return $clog2(window + 1);
   endfunction

   function automatic int bin_count(input int sample_w);
      return 1 << sample_w;
   endfunction
endpackage

// File: rtl/hm_thermo.sv
module hm_thermo #(
   parameter int SAMPLE_W = 4,
   localparam int NBINS = 1 << SAMPLE_W
) (
   input  logic [SAMPLE_W-1:0] value,
   output logic [NBINS-1:0]    mask
);
   // Bin b is touched by every sample whose value is b or less
   for (genvar b = 0; b < NBINS; b++) begin : g_bit
      assign mask[b] = (SAMPLE_W'(b) >= value);
   end
endmodule

// File: rtl/hm_delay.sv
module hm_delay #(
   parameter int SAMPLE_W = 4,
   parameter int DEPTH    = 7
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                push,
   input  logic [SAMPLE_W-1:0] din,
   output logic [SAMPLE_W-1:0] dout,
   output logic                dout_valid
);
   logic [SAMPLE_W-1:0] data_q [DEPTH];
   logic [DEPTH-1:0]    vld_q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) begin
            data_q[i] <= '0;
            vld_q[i]  <= 1'b0;
         end else if (push) begin
            if (i == 0) begin
               data_q[i] <= din;
               vld_q[i]  <= 1'b1;
            end else begin
               data_q[i] <= data_q[(i > 0) ? i-1 : 0];
               vld_q[i]  <= vld_q[(i > 0) ? i-1 : 0];
            end
         end
      end
   end

   assign dout       = data_q[DEPTH-1];
   assign dout_valid = vld_q[DEPTH-1];
endmodule

// File: rtl/hm_bins.sv
module hm_bins #(
   parameter int NBINS = 16,
   parameter int CNT_W = 3
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [NBINS-1:0]       add_en,
   input  logic [NBINS-1:0]       sub_en,
   output logic [NBINS*CNT_W-1:0] counts_flat
);
   for (genvar b = 0; b < NBINS; b++) begin : g_bin
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (rst)
            cnt_q <= '0;
         else if (add_en[b] && !sub_en[b])
            cnt_q <= cnt_q + 1'b1;
         else if (sub_en[b] && !add_en[b])
            cnt_q <= cnt_q - 1'b1;
      end
      assign counts_flat[b*CNT_W +: CNT_W] = cnt_q;
   end
endmodule

// File: rtl/hm_select.sv
module hm_select #(
   parameter int SAMPLE_W = 4,
   parameter int CNT_W    = 3,
   localparam int NBINS = 1 << SAMPLE_W
) (
   input  logic [NBINS*CNT_W-1:0] counts_flat,
   output logic [SAMPLE_W-1:0]    median
);
   logic [CNT_W-1:0] total;
   logic [CNT_W-1:0] rank;
   logic [NBINS-1:0] reached;

   assign total = counts_flat[(NBINS-1)*CNT_W +: CNT_W];
   assign rank  = (total >> 1) + 1'b1;

   for (genvar b = 0; b < NBINS; b++) begin : g_cmp
      assign reached[b] = (counts_flat[b*CNT_W +: CNT_W] >= rank);
   end

   // Lowest bin index whose count reaches the rank
   always_comb begin
      median = '0;
      for (int b = NBINS-1; b >= 0; b--) begin
         if (reached[b]) median = SAMPLE_W'(b);
      end
   end
endmodule

// File: rtl/hist_median.sv
module hist_median
   import hist_median_pkg::*;
#(
   parameter int SAMPLE_W = 4,
   parameter int WINDOW   = 7,
   localparam int NBINS = bin_count(SAMPLE_W),
   localparam int CNT_W = count_width(WINDOW)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_data,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_data
);
   if (WINDOW < 3 || (WINDOW % 2) == 0) begin : g_bad_window
      $error("hist_median: WINDOW must be odd and at least 3");
   end
   if (SAMPLE_W < 1 || SAMPLE_W > 10) begin : g_bad_width
      $error("hist_median: SAMPLE_W must lie in 1..10");
   end

   logic [NBINS-1:0]       new_mask, old_mask, add_en, sub_en;
   logic [SAMPLE_W-1:0]    old_data, med;
   logic                   old_valid, upd_q;
   logic [NBINS*CNT_W-1:0] counts_flat;

   hm_delay #(.SAMPLE_W(SAMPLE_W), .DEPTH(WINDOW)) i_delay (
      .clk(clk), .rst(rst), .push(in_valid), .din(in_data),
      .dout(old_data), .dout_valid(old_valid));

   hm_thermo #(.SAMPLE_W(SAMPLE_W)) i_new_mask (.value(in_data),  .mask(new_mask));
   hm_thermo #(.SAMPLE_W(SAMPLE_W)) i_old_mask (.value(old_data), .mask(old_mask));

   assign add_en = new_mask & {NBINS{in_valid}};
   assign sub_en = old_mask & {NBINS{in_valid & old_valid}};

   hm_bins #(.NBINS(NBINS), .CNT_W(CNT_W)) i_bins (
      .clk(clk), .rst(rst), .add_en(add_en), .sub_en(sub_en),
      .counts_flat(counts_flat));

   hm_select #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) i_select (
      .counts_flat(counts_flat), .median(med));

   always_ff @(posedge clk) begin
      if (rst) begin
         upd_q     <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         upd_q     <= in_valid;
         out_valid <= upd_q;
         if (upd_q) out_data <= med;
      end
   end
endmodule

// File: rtl/hist_median_chk.sv
module hist_median_chk #(
   parameter int SAMPLE_W = 4,
   parameter int WINDOW   = 7,
   localparam int NBINS = 1 << SAMPLE_W,
   localparam int CNT_W = $clog2(WINDOW + 1)
) (
   input logic                   clk,
   input logic                   rst,
   input logic                   in_valid,
   input logic                   out_valid,
   input logic [NBINS*CNT_W-1:0] counts_flat
);
   logic [1:0]       cyc;
   logic [CNT_W-1:0] top;
   assign top = counts_flat[(NBINS-1)*CNT_W +: CNT_W];

   always_ff @(posedge clk) begin
      if (rst) cyc <= '0;
      else if (cyc != 2'd3) cyc <= cyc + 1'b1;
   end

   assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
      (cyc >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

   assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
      ((cyc >= 2'd1) && !$past(in_valid)) |-> $stable(top));

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
      top <= CNT_W'(WINDOW));

   assert_single_step_R7: assert property (@(posedge clk) disable iff (rst)
      (cyc >= 2'd1) |-> ({1'b0, top} <= {1'b0, $past(top)} + 1'b1));

   always @(posedge clk) begin
      if (!rst) begin
         for (int b = 0; b < NBINS-1; b++) begin
            assert_cumulative_R4: assert (counts_flat[b*CNT_W +: CNT_W]
                                          <= counts_flat[(b+1)*CNT_W +: CNT_W]);
         end
      end
   end
endmodule

bind hist_median hist_median_chk #(.SAMPLE_W(SAMPLE_W), .WINDOW(WINDOW)) i_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
   .counts_flat(counts_flat));

// File: tb/test_hist_median.sv
module test_hist_median;
   localparam int CLK_P    = 10;
   localparam int SAMPLE_W = 4;
   localparam int WINDOW   = 7;
   localparam int MAXV     = (1 << SAMPLE_W) - 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [SAMPLE_W-1:0] in_data = '0;
   logic out_valid;
   logic [SAMPLE_W-1:0] out_data;

   int checks = 0, errors = 0;
   int win[$];
   bit e1_v = 0, e2_v = 0;
   int e1_d = 0, e2_d = 0;
   string e1_tag = "", e2_tag = "";
   int unsigned seed = 32'h1234_5678;

   always #(CLK_P/2) clk = ~clk;

   hist_median #(.SAMPLE_W(SAMPLE_W), .WINDOW(WINDOW)) i_hist_median (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data));

   function automatic int rnd(input int modulo);
      seed = seed * 1103515245 + 12345;
      return int'((seed >> 8) % modulo);
   endfunction

   // One cycle: check what the pipeline must show now, then drive new input
   task automatic step(input bit v, input int d, input string tag);
      int tmp[$];
      @(negedge clk);
      checks++;
      if (out_valid !== e2_v) begin
         errors++;
         $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, e2_v);
      end else if (e2_v) begin
         checks++;
         if (out_data !== e2_d[SAMPLE_W-1:0]) begin
            errors++;
            $display("FAIL %s out_data actual=%0d expected=%0d", e2_tag, out_data, e2_d);
         end
      end
      e2_v = e1_v; e2_d = e1_d; e2_tag = e1_tag;
      e1_v = v;
      if (v) begin
         win.push_back(d);
         if (win.size() > WINDOW) void'(win.pop_front());
         tmp = win;
         tmp.sort();
         e1_d = tmp[tmp.size() / 2];
         e1_tag = tag;
      end
      in_valid = v;
      in_data  = d[SAMPLE_W-1:0];
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0;
      repeat (2) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 out_valid in reset actual=%0b expected=0", out_valid);
      end
      rst = 1'b0;
      win.delete();
      e1_v = 0; e2_v = 0;
   endtask

   task automatic drain();
      repeat (3) step(0, 0, "R2");
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      do_reset();
      // R3 / R8: every value alone after reset, extremes included
      for (int v = 0; v <= MAXV; v++) begin
         do_reset();
         step(1, v, (v == 0 || v == MAXV) ? "R8" : "R3");
         drain();
      end
      // R3, R4, R9: ascending ramp back to back, partial then full window
      do_reset();
      for (int v = 0; v <= MAXV; v++) step(1, v, (v < WINDOW) ? "R3" : "R9");
      drain();
      // R5: descending ramp, the leaving sample decides each result
      do_reset();
      for (int v = MAXV; v >= 0; v--) step(1, v, (MAXV - v < WINDOW) ? "R3" : "R5");
      drain();
      // R6 / R7: narrow value range with random idle gaps
      do_reset();
      for (int i = 0; i < 200; i++) begin
         step(1, rnd(4), "R7");
         for (int g = rnd(4); g > 0; g--) step(0, 0, "R6");
      end
      drain();
      // R4: full-range random stream
      for (int i = 0; i < 300; i++) step(1, rnd(MAXV + 1), "R4");
      drain();
      // R8: alternating extremes
      for (int i = 0; i < 20; i++) step(1, (i % 3 == 0) ? 0 : MAXV, "R8");
      drain();
      // R1: reset in the middle of large values, then one small sample
      for (int i = 0; i < 5; i++) step(1, MAXV, "R4");
      do_reset();
      step(1, 3, "R1");
      drain();
      for (int i = 0; i < 2 * WINDOW; i++) step(1, i % 5, "R1");
      drain();
      finish_run();
   end
endmodule